// File: doc/BRIEF.md
# Dual Wiper Register Controller with Nonvolatile Backup

This block executes commands for two 10-bit wiper positions (0 to 1023), each backed by a nonvolatile copy. A serial receiver hands it decoded frames of command code, address and data. The block writes, saves, recalls and reads back wiper values. An active-high ready output drops while a slow operation is in progress. The nonvolatile copies are modelled as a register array. Every slow operation has its own busy length, set as a parameter in system clock cycles.

Two control inputs act outside the frame path. A low write-protect input freezes the wipers and their backups against every command. A rising edge on the active-low preset input reloads both wipers from their backups, and write-protect does not block it. After reset the block first performs a power-on recall. The backups start at midscale (512), so the wipers come up at midscale.

Top module: `wnv_ctrl`

## Requirements
- R1: During reset and for T_PWRUP cycles after it, ready is low. When ready rises, both wipers hold 512, because the backups start at midscale.
- R2: Command 11 loads the data field into the wiper at address 0 or 1 on the next clock edge, and ready stays high. Any address of 2 or more has no effect.
- R3: Command 2 copies the addressed wiper into its backup. Command 3 writes the data field into the addressed backup. Both hold ready low for exactly T_STORE cycles, and the backup changes when ready rises.
- R4: Command 1 reloads the addressed wiper from its backup on the next edge, with ready staying high. Command 8 does the same reload with ready held low for T_RECALL cycles.
- R5: Command 9 places the addressed backup on the readback output, and command 10 places the addressed wiper there. Each holds ready low for T_PEEK cycles, and the value stays on the output until the next readback.
- R6: A rising edge of preset_n holds ready low for T_PRESET cycles, then loads both wipers from their backups. If the edge arrives while an operation is still running, the reload starts right after that operation, and ready stays low through both.
- R7: While wp_n is low, commands 1, 2, 3, 8 and 11 have no effect and leave ready high. Readback commands and the preset reload still work.
- R8: A frame that arrives while ready is low, or in the same cycle as a preset edge, is dropped. It sets busy_err, which stays high until reset.
- R9: Command codes 0, 4 to 7 and 12 to 15 change nothing and leave ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | One-cycle strobe marking a decoded frame |
| frame_cmd | input | 4 | Command code of the frame |
| frame_addr | input | ADDR_W | Wiper address of the frame |
| frame_data | input | WBITS | Data field of the frame |
| wp_n | input | 1 | Active-low write protect |
| preset_n | input | 1 | Active-low preset; the rising edge starts a reload |
| ready | output | 1 | High when idle, low while an operation runs |
| wipers | output | NW*WBITS | Wiper positions; wiper 0 in the low bits |
| rdbk | output | WBITS | Last readback value |
| busy_err | output | 1 | Sticky flag for dropped frames |

## Verification
The bench drives distinct values into the two addresses, so a swapped address or a copy into the wrong slot shows up. It also makes backup and wiper values differ before each recall or readback, which exposes a command reading the wrong source. The low time of ready is counted for each slow command, the preset and power-on, which separates the durations and catches an off-by-one in the counter. Write-protected frames, unknown codes, an out-of-range address, a frame sent while busy and a preset edge during a store each test that an ignored input leaves the outputs unchanged, or that the deferred reload picks up the newly stored backup.

// File: rtl/wnv_pkg.sv
package wnv_pkg;
  localparam logic [3:0] CMD_NOP      = 4'd0;
  localparam logic [3:0] CMD_RECALL   = 4'd1;
  localparam logic [3:0] CMD_SAVE_W   = 4'd2;
  localparam logic [3:0] CMD_SAVE_D   = 4'd3;
  localparam logic [3:0] CMD_RECALL_B = 4'd8;
  localparam logic [3:0] CMD_PEEK_NV  = 4'd9;
  localparam logic [3:0] CMD_PEEK_W   = 4'd10;
  localparam logic [3:0] CMD_SET      = 4'd11;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_SET_W,
    OP_RECALL_NOW,
    OP_SAVE_W,
    OP_SAVE_D,
    OP_RECALL_SLOW,
    OP_PEEK_NV,
    OP_PEEK_W,
    OP_PRESET,
    OP_PWRUP
  } op_e;
endpackage

// File: rtl/wnv_decode.sv
module wnv_decode
  import wnv_pkg::*;
#(
  parameter int NW     = 2,
  parameter int ADDR_W = 4,
  localparam int IDX_W = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic [3:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp_n,
  output op_e               kind,
  output logic              slow,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] ADDR_LIM = ADDR_W'(NW);

  logic addr_ok;
  op_e  raw;

  assign addr_ok = (addr < ADDR_LIM);
  assign idx     = addr[IDX_W-1:0];

  always_comb begin
    case (cmd)
      CMD_SET:      raw = wp_n ? OP_SET_W       : OP_NONE;
      CMD_RECALL:   raw = wp_n ? OP_RECALL_NOW  : OP_NONE;
      CMD_SAVE_W:   raw = wp_n ? OP_SAVE_W      : OP_NONE;
      CMD_SAVE_D:   raw = wp_n ? OP_SAVE_D      : OP_NONE;
      CMD_RECALL_B: raw = wp_n ? OP_RECALL_SLOW : OP_NONE;
      CMD_PEEK_NV:  raw = OP_PEEK_NV;
      CMD_PEEK_W:   raw = OP_PEEK_W;
      default:      raw = OP_NONE;
    endcase
    kind = addr_ok ? raw : OP_NONE;
    slow = (kind == OP_SAVE_W) || (kind == OP_SAVE_D) || (kind == OP_RECALL_SLOW) ||
           (kind == OP_PEEK_NV) || (kind == OP_PEEK_W);
  end
endmodule

// File: rtl/wnv_timer.sv
module wnv_timer #(
  parameter int CNT_W = 8,
  parameter int INIT  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             active,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_d;

  assign done = active && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    act_d = active;
    if (load) begin
      cnt_d = load_val;
      act_d = 1'b1;
    end else if (done) begin
      act_d = 1'b0;
    end else if (active) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_W'(INIT - 1);
      active <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      active <= act_d;
    end
  end
endmodule

// File: rtl/wnv_bank.sv
module wnv_bank #(
  parameter int NW    = 2,
  parameter int WBITS = 10,
  localparam int IDX_W = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [IDX_W-1:0]    widx,
  input  logic [WBITS-1:0]    wdata,
  output logic [NW*WBITS-1:0] rd_flat
);
  localparam logic [WBITS-1:0] MID = WBITS'(1) << (WBITS - 1);

  for (genvar g = 0; g < NW; g++) begin : g_cell
    logic en;
    logic [WBITS-1:0] cell_q;
    assign en = we && (widx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cell_q <= MID;
      else if (en) cell_q <= wdata;
    end
    assign rd_flat[g*WBITS +: WBITS] = cell_q;
  end
endmodule

// File: rtl/wnv_ctrl.sv
module wnv_ctrl
  import wnv_pkg::*;
#(
  parameter int NW       = 2,
  parameter int WBITS    = 10,
  parameter int ADDR_W   = 4,
  parameter int T_STORE  = 750000,
  parameter int T_RECALL = 1000,
  parameter int T_PEEK   = 350,
  parameter int T_PRESET = 1500,
  parameter int T_PWRUP  = 1500
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_valid,
  input  logic [3:0]          frame_cmd,
  input  logic [ADDR_W-1:0]   frame_addr,
  input  logic [WBITS-1:0]    frame_data,
  input  logic                wp_n,
  input  logic                preset_n,
  output logic                ready,
  output logic [NW*WBITS-1:0] wipers,
  output logic [WBITS-1:0]    rdbk,
  output logic                busy_err
);
  localparam int IDX_W = (NW > 1) ? $clog2(NW) : 1;
  localparam int T_A   = (T_STORE > T_RECALL) ? T_STORE : T_RECALL;
  localparam int T_B   = (T_PEEK > T_PRESET) ? T_PEEK : T_PRESET;
  localparam int T_C   = (T_A > T_B) ? T_A : T_B;
  localparam int T_MAX = (T_C > T_PWRUP) ? T_C : T_PWRUP;
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam logic [ADDR_W-1:0] ADDR_LIM = ADDR_W'(NW);

  op_e              dec_kind;
  logic             dec_slow;
  logic [IDX_W-1:0] dec_idx;

  op_e              op_q, op_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [WBITS-1:0] data_q, data_d;
  logic             pre_prev, pend_q, pend_d;
  logic             err_d;
  logic [WBITS-1:0] rdbk_d;
  logic [WBITS-1:0] wip_q [NW];
  logic [WBITS-1:0] wip_d [NW];
  logic [NW*WBITS-1:0] nv_flat;

  logic             act, done, load;
  logic [CNT_W-1:0] load_val;
  logic             pre_rise, accept, launch_pre, launch_frm;
  logic             nv_we;
  logic [WBITS-1:0] nv_wdata;

  wnv_decode #(.NW(NW), .ADDR_W(ADDR_W)) u_dec (
    .cmd(frame_cmd), .addr(frame_addr), .wp_n(wp_n),
    .kind(dec_kind), .slow(dec_slow), .idx(dec_idx)
  );

  wnv_timer #(.CNT_W(CNT_W), .INIT(T_PWRUP)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .active(act), .done(done)
  );

  wnv_bank #(.NW(NW), .WBITS(WBITS)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(nv_we), .widx(idx_q),
    .wdata(nv_wdata), .rd_flat(nv_flat)
  );

  assign ready      = !act;
  assign pre_rise   = preset_n && !pre_prev;
  assign accept     = frame_valid && !act && !pre_rise;
  assign launch_pre = (pre_rise && !act) || (done && (pend_q || pre_rise));
  assign launch_frm = accept && dec_slow;
  assign load       = launch_pre || launch_frm;

  always_comb begin
    if (launch_pre) load_val = CNT_W'(T_PRESET - 1);
    else begin
      case (dec_kind)
        OP_SAVE_W, OP_SAVE_D: load_val = CNT_W'(T_STORE - 1);
        OP_RECALL_SLOW:       load_val = CNT_W'(T_RECALL - 1);
        default:              load_val = CNT_W'(T_PEEK - 1);
      endcase
    end
  end

  always_comb begin
    op_d   = op_q;
    idx_d  = idx_q;
    data_d = data_q;
    if (launch_pre) op_d = OP_PRESET;
    else if (launch_frm) begin
      op_d   = dec_kind;
      idx_d  = dec_idx;
      data_d = frame_data;
    end
    pend_d = launch_pre ? 1'b0 : ((pre_rise && act) ? 1'b1 : pend_q);
    err_d  = busy_err || (frame_valid && (act || pre_rise));
  end

  assign nv_we    = done && ((op_q == OP_SAVE_W) || (op_q == OP_SAVE_D));
  assign nv_wdata = (op_q == OP_SAVE_W) ? wip_q[idx_q] : data_q;

  always_comb begin
    rdbk_d = rdbk;
    if (done && op_q == OP_PEEK_NV) rdbk_d = nv_flat[idx_q*WBITS +: WBITS];
    if (done && op_q == OP_PEEK_W)  rdbk_d = wip_q[idx_q];
    for (int i = 0; i < NW; i++) begin
      wip_d[i] = wip_q[i];
      if (done && (op_q == OP_PRESET || op_q == OP_PWRUP))
        wip_d[i] = nv_flat[i*WBITS +: WBITS];
      if (done && op_q == OP_RECALL_SLOW && idx_q == IDX_W'(i))
        wip_d[i] = nv_flat[i*WBITS +: WBITS];
      if (accept && dec_kind == OP_RECALL_NOW && dec_idx == IDX_W'(i))
        wip_d[i] = nv_flat[i*WBITS +: WBITS];
      if (accept && dec_kind == OP_SET_W && dec_idx == IDX_W'(i))
        wip_d[i] = frame_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_PWRUP;
      idx_q    <= '0;
      data_q   <= '0;
      pre_prev <= 1'b1;
      pend_q   <= 1'b0;
      busy_err <= 1'b0;
      rdbk     <= '0;
    end else begin
      op_q     <= op_d;
      idx_q    <= idx_d;
      data_q   <= data_d;
      pre_prev <= preset_n;
      pend_q   <= pend_d;
      busy_err <= err_d;
      rdbk     <= rdbk_d;
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_wip
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wip_q[g] <= '0;
      else        wip_q[g] <= wip_d[g];
    end
    assign wipers[g*WBITS +: WBITS] = wip_q[g];
  end

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err |=> busy_err);

  a_r2_set_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && ready && !pre_rise && frame_cmd == CMD_SET) |=> ready);

  a_r3_store_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && ready && !pre_rise && wp_n && frame_cmd == CMD_SAVE_W &&
     frame_addr < ADDR_LIM) |=> !ready);

  a_r5_peek_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && ready && !pre_rise && frame_cmd == CMD_PEEK_W &&
     frame_addr < ADDR_LIM) |=> !ready);

  a_r6_preset_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_rise && ready) |=> !ready);

  a_r7_wp_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready) && $past(!wp_n)) |-> $stable(wipers));

  a_r9_unknown_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && ready && !pre_rise && frame_cmd[2]) |=> (ready && $stable(wipers)));
endmodule

// File: tb/test_wnv_ctrl.sv
module test_wnv_ctrl;
  localparam int NW = 2, WB = 10, AW = 4;
  localparam int TS = 40, TR = 8, TP = 5, TPR = 12, TPU = 10;

  logic clk, rst_n, frame_valid, wp_n, preset_n;
  logic [3:0] frame_cmd;
  logic [AW-1:0] frame_addr;
  logic [WB-1:0] frame_data;
  logic ready, busy_err;
  logic [NW*WB-1:0] wipers;
  logic [WB-1:0] rdbk;

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct {
    logic [WB-1:0] w0, w1, rd;
    logic          err;
  } snap_t;
  snap_t exp_q[$];
  string tag_q[$];

  logic [WB-1:0] m_w0, m_w1, m_rd;
  logic          m_err;

  wnv_ctrl #(.NW(NW), .WBITS(WB), .ADDR_W(AW), .T_STORE(TS), .T_RECALL(TR),
             .T_PEEK(TP), .T_PRESET(TPR), .T_PWRUP(TPU)) i_wnv_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_cmd(frame_cmd),
    .frame_addr(frame_addr), .frame_data(frame_data), .wp_n(wp_n),
    .preset_n(preset_n), .ready(ready), .wipers(wipers), .rdbk(rdbk),
    .busy_err(busy_err));

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic push(string tag);
    snap_t s;
    s.w0 = m_w0; s.w1 = m_w1; s.rd = m_rd; s.err = m_err;
    exp_q.push_back(s);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      snap_t s;
      string t;
      s = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({t, " wiper0"}, int'(wipers[WB-1:0]), int'(s.w0));
      chk({t, " wiper1"}, int'(wipers[2*WB-1:WB]), int'(s.w1));
      chk({t, " rdbk"}, int'(rdbk), int'(s.rd));
      chk({t, " busy_err"}, int'(busy_err), int'(s.err));
    end
  end

  task automatic wait_ready(output int lowcnt);
    lowcnt = 0;
    while (ready !== 1'b1) begin
      lowcnt++;
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [3:0] c, input int a, input int d, output int lowcnt);
    @(negedge clk);
    frame_valid = 1; frame_cmd = c; frame_addr = AW'(a); frame_data = WB'(d);
    @(negedge clk);
    frame_valid = 0;
    wait_ready(lowcnt);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int n;
    rst_n = 0; frame_valid = 0; frame_cmd = 0; frame_addr = 0; frame_data = 0;
    wp_n = 1; preset_n = 1;
    m_w0 = 512; m_w1 = 512; m_rd = 0; m_err = 0;
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", int'(ready), 0);
    rst_n = 1;
    wait_ready(n);
    chk("R1 power-on busy cycles", n, TPU);
    push("R1 midscale after power-on");

    send(4'd11, 0, 100, n); chk("R2 set keeps ready", n, 0);
    m_w0 = 100; push("R2 set wiper0");
    send(4'd11, 1, 900, n); m_w1 = 900; push("R2 set wiper1");
    send(4'd11, 2, 55, n);  push("R2 out-of-range address");

    send(4'd2, 0, 0, n); chk("R3 save wiper busy", n, TS);
    send(4'd3, 1, 333, n); chk("R3 save data busy", n, TS);
    send(4'd9, 0, 0, n); chk("R5 peek busy", n, TP);
    m_rd = 100; push("R3 backup0 from wiper");
    send(4'd9, 1, 0, n); m_rd = 333; push("R3 backup1 from data");
    send(4'd10, 1, 0, n); m_rd = 900; push("R5 peek wiper1");

    send(4'd11, 0, 5, n); m_w0 = 5; push("R2 set before recall");
    send(4'd1, 0, 0, n); chk("R4 fast recall no busy", n, 0);
    m_w0 = 100; push("R4 fast recall");
    send(4'd0, 0, 0, n); push("R9 nop");
    send(4'd8, 1, 0, n); chk("R4 slow recall busy", n, TR);
    m_w1 = 333; push("R4 slow recall wiper1");

    send(4'd5, 0, 77, n); chk("R9 code 5 no busy", n, 0);
    send(4'd12, 1, 77, n); chk("R9 code 12 no busy", n, 0);
    push("R9 unknown codes");

    send(4'd11, 0, 1, n); m_w0 = 1; push("R2 set before protect");
    wp_n = 0;
    send(4'd11, 0, 7, n); chk("R7 protected set no busy", n, 0);
    send(4'd3, 0, 9, n); chk("R7 protected store no busy", n, 0);
    send(4'd1, 1, 0, n);
    push("R7 protected wipers unchanged");
    send(4'd9, 0, 0, n); chk("R7 peek allowed under protect", n, TP);
    m_rd = 100; push("R7 backup0 unchanged");
    @(negedge clk); preset_n = 0;
    @(negedge clk); preset_n = 1;
    @(negedge clk);
    wait_ready(n); chk("R6 preset busy", n, TPR);
    m_w0 = 100; m_w1 = 333; push("R6 preset reload under protect");
    wp_n = 1;

    @(negedge clk);
    frame_valid = 1; frame_cmd = 4'd3; frame_addr = 0; frame_data = 200;
    @(negedge clk);
    frame_valid = 0;
    n = 0;
    for (int k = 0; k < 10; k++) begin
      if (ready !== 1'b1) n++;
      @(negedge clk);
    end
    frame_valid = 1; frame_cmd = 4'd11; frame_addr = 0; frame_data = 3;
    if (ready !== 1'b1) n++;
    @(negedge clk);
    frame_valid = 0; preset_n = 0;
    if (ready !== 1'b1) n++;
    @(negedge clk);
    preset_n = 1;
    while (ready !== 1'b1) begin
      n++;
      @(negedge clk);
    end
    chk("R6 deferred preset total busy", n, TS + TPR);
    m_w0 = 200; m_err = 1; push("R8 R6 dropped frame and deferred reload");
    send(4'd11, 1, 44, n); m_w1 = 44; push("R8 error stays set");

    while (exp_q.size() > 0) @(negedge clk);
    finished = 1;
    summary();
  end
endmodule